// File: doc/BRIEF.md
# Carry-Selected Constant Arithmetic Circuit

This is a combinational arithmetic unit of parameterised width. The input carry has two jobs. It feeds the low end of a ripple chain of one-bit full adders, and it also helps choose the operation. Operand `a` always drives one input of every adder. A small multiplexer in each bit drives the other adder input. That input is one of four values: the matching bit of `b`, its complement, a constant 0 or a constant 1. The mode bit `sel` and the input carry `cin` make the choice.

The multiplexer settings differ in the lowest bit, in bit 1 and in the bits above. Because of this, the two modes that use a constant add +3 or -3 to `a` without any stored constant. Results wrap modulo 2^WIDTH, and the carry leaving the top adder is brought out as `cout`. WIDTH must be at least 2.

Top module: `const_arith_unit`

## Requirements
- R1: With sel=0 and cin=0, {cout,d} equals the (WIDTH+1)-bit sum a + b.
- R2: With sel=0 and cin=1, d equals (a + 3) mod 2^WIDTH, and cout is 1 exactly when a + 3 reaches 2^WIDTH.
- R3: With sel=1 and cin=0, d equals (a - 3) mod 2^WIDTH, and cout is 1 exactly when a >= 3.
- R4: With sel=1 and cin=1, d equals (a - b) mod 2^WIDTH, and cout is 1 exactly when a >= b.
- R5: In the two constant modes (sel differs from cin), the value of b has no effect on d or cout.
- R6: Results wrap. With a = 2^WIDTH-1 the +3 mode gives d=2 and cout=1. With a=0 the -3 mode gives d=2^WIDTH-3 and cout=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand, fed straight to every adder |
| b | input | WIDTH | Second operand, used by the two b modes |
| sel | input | 1 | Mode bit: 0 selects an add, 1 selects a subtract |
| cin | input | 1 | Carry into bit 0; also chooses between the b operation and the constant operation |
| d | output | WIDTH | Result, modulo 2^WIDTH |
| cout | output | 1 | Carry out of the most significant adder |

## Verification
The block holds no state, so a fault in an operand multiplexer or a carry link shows on `d` or `cout` in the same evaluation as the input that exposes it. A bit-1 multiplexer with swapped inputs would give +1/-1 in place of +3/-3 at once. A broken carry link is seen only when an operand pattern sends a carry through that stage, so random operands are mixed with all-ones and zero operands that force a carry through every stage. In the constant modes, `b` is toggled while `a` is held, to show it has no effect on the result.

// File: rtl/const_arith_unit.sv
module const_arith_unit #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sel,
  input  logic             cin,
  output logic [WIDTH-1:0] d,
  output logic             cout
);

  logic [WIDTH-1:0] opnd;
  logic [WIDTH:0]   carry;
  logic [1:0]       mode;

  assign mode     = {sel, cin};
  assign carry[0] = cin;

  // per-bit operand choice, mode order 00,01,10,11
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i == 0) begin : g_lsb
        always_comb
          case (mode)
            2'b00:   opnd[i] = b[i];
            2'b01:   opnd[i] = 1'b0;
            2'b10:   opnd[i] = 1'b1;
            default: opnd[i] = ~b[i];
          endcase
      end else if (i == 1) begin : g_b1
        always_comb
          case (mode)
            2'b00:   opnd[i] = b[i];
            2'b01:   opnd[i] = 1'b1;
            2'b10:   opnd[i] = 1'b0;
            default: opnd[i] = ~b[i];
          endcase
      end else begin : g_hi
        always_comb
          case (mode)
            2'b00:   opnd[i] = b[i];
            2'b01:   opnd[i] = 1'b0;
            2'b10:   opnd[i] = 1'b1;
            default: opnd[i] = ~b[i];
          endcase
      end

      assign d[i]       = a[i] ^ opnd[i] ^ carry[i];
      assign carry[i+1] = (a[i] & opnd[i]) | (carry[i] & (a[i] ^ opnd[i]));
    end
  endgenerate

  assign cout = carry[WIDTH];

  always_comb begin
    if (mode == 2'b00)
      p_add_b_r1: assert ({cout, d} == ({1'b0, a} + {1'b0, b}))
        else $error("R1 sum mismatch");
    if (mode == 2'b11)
      p_sub_b_r4: assert ((d == WIDTH'(a - b)) && (cout == (a >= b)))
        else $error("R4 difference mismatch");
    if (mode == 2'b01)
      p_const_plus_r5: assert (opnd == WIDTH'(2))
        else $error("R5 operand depends on b");
    if (mode == 2'b10)
      p_const_minus_r5: assert (opnd == ~WIDTH'(2))
        else $error("R5 operand depends on b");
    if (mode == 2'b10)
      p_minus3_carry_r3: assert (cout == (a >= WIDTH'(3)))
        else $error("R3 carry mismatch");
  end

endmodule

// File: tb/const_arith_unit_bench.sv
module const_arith_unit_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a, b, d;
  logic sel, cin, cout;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  const_arith_unit #(.WIDTH(W)) u_const_arith_unit (
    .a(a), .b(b), .sel(sel), .cin(cin), .d(d), .cout(cout)
  );

  function automatic logic [W:0] expect_val(logic [W-1:0] x, logic [W-1:0] y,
                                            logic s, logic c);
    logic [W:0] xe;
    xe = {1'b0, x};
    case ({s, c})
      2'b00:   return xe + {1'b0, y};
      2'b01:   return xe + (W+1)'(3);
      2'b10:   return xe + (W+1)'((1 << W) - 3);
      default: return xe + {1'b0, ~y} + (W+1)'(1);
    endcase
  endfunction

  task automatic apply_check(logic [W-1:0] x, logic [W-1:0] y, logic s,
                             logic c, string req);
    logic [W:0] e;
    @(negedge clk);
    a = x; b = y; sel = s; cin = c;
    #1;
    e = expect_val(x, y, s, c);
    checks++;
    if ({cout, d} !== e) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d mode=%b%b got cout=%b d=%0d exp cout=%b d=%0d",
               req, x, y, s, c, cout, d, e[W], e[W-1:0]);
    end
  endtask

  task automatic b_ignored(logic [W-1:0] x, logic s, logic c);
    logic [W:0] first;
    @(negedge clk);
    a = x; b = '0; sel = s; cin = c;
    #1 first = {cout, d};
    b = '1;
    #1;
    checks++;
    if ({cout, d} !== first || first !== expect_val(x, '0, s, c)) begin
      errors++;
      $display("FAIL R5 a=%0d mode=%b%b got %0h exp %0h", x, s, c,
               {cout, d}, expect_val(x, '0, s, c));
    end
  endtask

  initial begin
    a = '0; b = '0; sel = 1'b0; cin = 1'b0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // idle inputs after reset: 0+0
    apply_check('0, '0, 0, 0, "R1");
    apply_check(8'hFF, 8'h01, 0, 0, "R1");
    apply_check(8'h80, 8'h80, 0, 0, "R1");
    apply_check(8'h05, 8'h00, 0, 1, "R2");
    apply_check(8'hFD, 8'h00, 0, 1, "R2");
    apply_check(8'h03, 8'h55, 1, 0, "R3");
    apply_check(8'h02, 8'hAA, 1, 0, "R3");
    apply_check(8'h10, 8'h10, 1, 1, "R4");
    apply_check(8'h00, 8'h01, 1, 1, "R4");
    apply_check(8'hFF, 8'hC3, 0, 1, "R6");
    apply_check(8'h00, 8'h3C, 1, 0, "R6");
    b_ignored(8'h41, 0, 1);
    b_ignored(8'h41, 1, 0);
    b_ignored(8'h01, 1, 0);
    for (int k = 0; k < 2000; k++) begin
      logic [1:0] m;
      m = 2'($urandom);
      apply_check(W'($urandom), W'($urandom), m[1], m[0],
                  m == 2'b00 ? "R1" : m == 2'b01 ? "R2" : m == 2'b10 ? "R3" : "R4");
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule